// File: doc/BRIEF.md
# Configurable Interrupt Pin Driver

This block turns an internal interrupt-pending flag into the level on one interrupt output pin. A two-bit mode input picks one of four pin behaviours. In the two level modes the pin shows the pending flag directly, either active low or active high. In the two pulse modes the pin rests at an idle level. Each new assertion of the pending flag produces one pulse of programmable length, either a low-going pulse or a high-going pulse.

The pin is driven from a register, so each input change shows on the pin one clock later. A pulse that has started always runs to its full length with the polarity it started with. A mode change that arrives during a pulse waits until the pulse has ended. Pulse length is sampled from the length input when the pulse starts.

Top module: `irq_pin_driver`

## Requirements
- R1: While reset is asserted, and after it is released, the pin is high and the mode is 00 (active-low level).
- R2: Mode 00 (mode_i = 2'b00): at each clock edge the pin takes the inverse of pend_i sampled at that edge.
- R3: Mode 01 (mode_i = 2'b01): at each clock edge the pin takes the value of pend_i sampled at that edge.
- R4: Mode 10 (mode_i = 2'b10): the pin idles high. When pend_i is sampled high one edge after it was sampled low, the pin goes low from that edge for L clocks and then returns high.
- R5: Mode 11 (mode_i = 2'b11): the pin idles low. A rising edge of pend_i produces a high pulse of L clocks, with the same timing as R4.
- R6: The pulse length L equals plen_i sampled at the edge that starts the pulse. A value of 0 gives L = 1.
- R7: Once a pulse has started, its length does not depend on pend_i. A pending flag that is held high gives exactly one pulse. A pending flag that falls during a pulse does not shorten it.
- R8: Rising edges of pend_i sampled while a pulse is active, including its last active clock, start no pulse and are dropped.
- R9: When no pulse is active, a mode change takes effect at the next clock edge. Entering a pulse mode while pend_i is already high produces no pulse.
- R10: A mode change during a pulse does not alter the pulse's polarity or length. The new mode takes effect at the first edge after the pulse's last active clock.
- R11: Changes on plen_i while a pulse is running do not alter that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| pend_i | input | 1 | Interrupt-pending condition |
| mode_i | input | 2 | Pin behaviour select (00 low level, 01 high level, 10 falling pulse, 11 rising pulse) |
| plen_i | input | PLEN_W | Pulse length in clocks; 0 means 1 |
| irq_pin_o | output | 1 | Interrupt pin level |

## Verification
Directed sequences check each mode on its own. In the level modes, the pin follows or inverts the pending flag. In the pulse modes, a held pending flag must give exactly one pulse, and a flag that falls early must not shorten the pulse. A minimum-length pulse of one clock checks the zero-length setting. A rising edge inside a pulse, and one on the pulse's last clock, are used to show that edges during a pulse are dropped rather than queued. Mode changes and length changes made during a pulse, compared with mode changes made while idle, separate the hold-until-done rule from an immediate switch. A long constrained-random run with rare mode changes and random pulse lengths then covers the same cases against a cycle model.

// File: rtl/irq_pin_pkg.sv
package irq_pin_pkg;

  typedef enum logic [1:0] {
    IRQ_LVL_LOW  = 2'b00,
    IRQ_LVL_HIGH = 2'b01,
    IRQ_PLS_FALL = 2'b10,
    IRQ_PLS_RISE = 2'b11
  } irq_mode_e;

  // Pulse signalling is selected by the upper mode bit.
  function automatic logic is_pulse(irq_mode_e m);
    return m[1];
  endfunction

  // Level the pin holds during an active pulse.
  function automatic logic pulse_level(irq_mode_e m);
    return m[0];
  endfunction

  // Level the pin rests at between pulses.
  function automatic logic pulse_idle(irq_mode_e m);
    return ~m[0];
  endfunction

  // Pin level for a level mode, given the pending flag.
  function automatic logic level_pin(irq_mode_e m, logic pend);
    return m[0] ? pend : ~pend;
  endfunction

endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic pend_i,
  output logic rise_o
);

  logic pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_i;
  end

  assign rise_o = pend_i & ~pend_q;

endmodule

// File: rtl/irq_mode_hold.sv
module irq_mode_hold
  import irq_pin_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  irq_mode_e mode_i,
  input  logic      hold_i,
  output irq_mode_e eff_mode_o,
  output irq_mode_e mode_q_o
);

  irq_mode_e mode_q;

  assign eff_mode_o = hold_i ? mode_q : mode_i;
  assign mode_q_o   = mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= IRQ_LVL_LOW;
    else        mode_q <= eff_mode_o;
  end

  // R10
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> mode_q == $past(mode_q));

endmodule

// File: rtl/irq_pulse_timer.sv
module irq_pulse_timer #(
  parameter int PLEN_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [PLEN_W-1:0] plen_i,
  output logic              busy_o,
  output logic              hold_o
);

  logic [PLEN_W-1:0] cnt_q;
  logic              puls_q;

  // Clocks remaining after the first one; a zero length counts as one.
  function automatic logic [PLEN_W-1:0] first_cnt(logic [PLEN_W-1:0] p);
    return (p == '0) ? '0 : p - 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      puls_q <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= first_cnt(plen_i);
      puls_q <= 1'b1;
    end else if (cnt_q != '0) begin
      cnt_q  <= cnt_q - 1'b1;
    end else begin
      puls_q <= 1'b0;
    end
  end

  assign busy_o = puls_q;
  assign hold_o = puls_q & (cnt_q != '0);

  // R6
  cnt_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (puls_q && cnt_q != '0 && !start_i) |=> (cnt_q == $past(cnt_q) - 1'b1) && puls_q);

  // R7
  pulse_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (puls_q && cnt_q == '0 && !start_i) |=> !puls_q);

endmodule

// File: rtl/irq_pin_driver.sv
module irq_pin_driver
  import irq_pin_pkg::*;
#(
  parameter int PLEN_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pend_i,
  input  logic [1:0]        mode_i,
  input  logic [PLEN_W-1:0] plen_i,
  output logic              irq_pin_o
);

  logic      rise;
  logic      busy;
  logic      hold;
  logic      start;
  logic      pin_d;
  logic      pin_q;
  irq_mode_e eff_mode;
  irq_mode_e mode_q;

  irq_edge_det u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .pend_i (pend_i),
    .rise_o (rise)
  );

  irq_mode_hold u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (irq_mode_e'(mode_i)),
    .hold_i     (hold),
    .eff_mode_o (eff_mode),
    .mode_q_o   (mode_q)
  );

  assign start = rise & is_pulse(eff_mode) & ~busy;

  irq_pulse_timer #(.PLEN_W(PLEN_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start),
    .plen_i  (plen_i),
    .busy_o  (busy),
    .hold_o  (hold)
  );

  always_comb begin
    if (hold || start)           pin_d = pulse_level(eff_mode);
    else if (is_pulse(eff_mode)) pin_d = pulse_idle(eff_mode);
    else                         pin_d = level_pin(eff_mode, pend_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b1;
    else        pin_q <= pin_d;
  end

  assign irq_pin_o = pin_q;

  // R3
  level_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b01 && !hold) |=> irq_pin_o == $past(pend_i));

  // R2
  level_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b00 && !hold) |=> irq_pin_o == !$past(pend_i));

  // R4 R5
  pulse_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> irq_pin_o == pulse_level(mode_q));

  // R8
  pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(rise) && $past(!busy));

endmodule

// File: tb/sim_irq_pin_driver.sv
`timescale 1ns/1ps
module sim_irq_pin_driver;

  localparam int PLEN_W = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              pend_i = 1'b0;
  logic [1:0]        mode_i = 2'b00;
  logic [PLEN_W-1:0] plen_i = '0;
  logic              irq_pin_o;

  int nchk  = 0;
  int nfail = 0;
  bit done  = 0;

  // reference model state
  logic [1:0]        m_mode;
  logic              m_pend_d;
  logic              m_puls;
  int                m_rem;
  logic              m_pin;

  always #2.5 clk = ~clk;

  irq_pin_driver #(.PLEN_W(PLEN_W)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .pend_i    (pend_i),
    .mode_i    (mode_i),
    .plen_i    (plen_i),
    .irq_pin_o (irq_pin_o)
  );

  function automatic int exp_len(logic [PLEN_W-1:0] p);
    return (p == 0) ? 1 : int'(p);
  endfunction

  function automatic string mode_tag(logic [1:0] m);
    case (m)
      2'b00:   return "R2";
      2'b01:   return "R3";
      2'b10:   return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(logic got, logic expv, string tag);
    nchk++;
    if (got !== expv) begin
      nfail++;
      $display("FAIL %s at %0t: pin=%b expected=%b", tag, $time, got, expv);
    end
  endtask

  task automatic model_reset();
    m_mode = 2'b00; m_pend_d = 1'b0; m_puls = 1'b0; m_rem = 0; m_pin = 1'b1;
  endtask

  // One clock of the requirements, applied to inputs p, m, l.
  task automatic model_step(logic p, logic [1:0] m, logic [PLEN_W-1:0] l);
    logic       hold_now;
    logic [1:0] eff;
    hold_now = m_puls && (m_rem != 0);
    eff = hold_now ? m_mode : m;
    if (hold_now) begin
      m_pin = eff[0];
      m_rem = m_rem - 1;
    end else if (eff[1] && p && !m_pend_d && !m_puls) begin
      m_pin  = eff[0];
      m_rem  = exp_len(l) - 1;
      m_puls = 1'b1;
    end else begin
      m_puls = 1'b0;
      m_pin  = eff[1] ? ~eff[0] : (eff[0] ? p : ~p);
    end
    m_mode   = eff;
    m_pend_d = p;
  endtask

  task automatic step(logic p, logic [1:0] m, logic [PLEN_W-1:0] l);
    @(negedge clk);
    pend_i = p; mode_i = m; plen_i = l;
    @(posedge clk);
    model_step(p, m, l);
    #1;
    check(irq_pin_o, m_pin, mode_tag(m_mode));
  endtask

  task automatic expect_pin(logic expv, string tag);
    check(irq_pin_o, expv, tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    expect_pin(1'b1, "R1");            // R1 in reset
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    expect_pin(1'b1, "R1");            // R1 after release, pend low, mode 00

    // R2 active-low level
    step(1, 2'b00, 0); expect_pin(1'b0, "R2");
    step(0, 2'b00, 0); expect_pin(1'b1, "R2");
    // R3 active-high level
    step(1, 2'b01, 0); expect_pin(1'b1, "R3");
    step(0, 2'b01, 0); expect_pin(1'b0, "R3");

    // R4 falling pulse, L=3, pending held high: one pulse only (R7)
    step(0, 2'b10, 3); expect_pin(1'b1, "R4");
    step(1, 2'b10, 3); expect_pin(1'b0, "R4");
    step(1, 2'b10, 3); expect_pin(1'b0, "R4");
    step(1, 2'b10, 3); expect_pin(1'b0, "R6");
    step(1, 2'b10, 3); expect_pin(1'b1, "R7");
    step(1, 2'b10, 3); expect_pin(1'b1, "R7");
    step(0, 2'b10, 3); expect_pin(1'b1, "R4");

    // R6 zero length gives one clock
    step(1, 2'b10, 0); expect_pin(1'b0, "R6");
    step(0, 2'b10, 0); expect_pin(1'b1, "R6");

    // R5 rising pulse L=2, pending falls early (R7)
    step(0, 2'b11, 2); expect_pin(1'b0, "R5");
    step(1, 2'b11, 2); expect_pin(1'b1, "R5");
    step(0, 2'b11, 2); expect_pin(1'b1, "R7");
    step(0, 2'b11, 2); expect_pin(1'b0, "R5");

    // R8 rising edge inside a pulse is dropped
    step(1, 2'b11, 4); expect_pin(1'b1, "R8");
    step(0, 2'b11, 4); expect_pin(1'b1, "R8");
    step(1, 2'b11, 4); expect_pin(1'b1, "R8");
    step(0, 2'b11, 4); expect_pin(1'b1, "R8");
    step(0, 2'b11, 4); expect_pin(1'b0, "R8");
    step(0, 2'b11, 4); expect_pin(1'b0, "R8");
    // R8 rising edge on the last active clock is dropped
    step(1, 2'b11, 2); expect_pin(1'b1, "R8");
    step(0, 2'b11, 2); expect_pin(1'b1, "R8");
    step(1, 2'b11, 2); expect_pin(1'b0, "R8");
    step(1, 2'b11, 2); expect_pin(1'b0, "R8");
    step(0, 2'b11, 2); expect_pin(1'b0, "R8");

    // R11 length change during a pulse
    step(0, 2'b10, 2); expect_pin(1'b1, "R11");
    step(1, 2'b10, 2); expect_pin(1'b0, "R11");
    step(1, 2'b10, 7); expect_pin(1'b0, "R11");
    step(1, 2'b10, 7); expect_pin(1'b1, "R11");
    step(0, 2'b10, 7); expect_pin(1'b1, "R11");

    // R10 mode change during a pulse
    step(1, 2'b10, 3); expect_pin(1'b0, "R10");
    step(0, 2'b00, 3); expect_pin(1'b0, "R10");
    step(0, 2'b00, 3); expect_pin(1'b0, "R10");
    step(0, 2'b00, 3); expect_pin(1'b1, "R10");
    step(1, 2'b00, 3); expect_pin(1'b0, "R10");

    // R9 mode change while idle, pending already high
    step(0, 2'b00, 1); expect_pin(1'b1, "R9");
    step(0, 2'b11, 1); expect_pin(1'b0, "R9");
    step(0, 2'b10, 1); expect_pin(1'b1, "R9");
    step(1, 2'b00, 1); expect_pin(1'b0, "R9");
    step(1, 2'b11, 1); expect_pin(1'b0, "R9");
    step(1, 2'b10, 1); expect_pin(1'b1, "R9");

    // constrained random against the model
    for (int i = 0; i < 4000; i++) begin
      logic              p;
      logic [1:0]        m;
      logic [PLEN_W-1:0] l;
      p = ($urandom_range(0, 3) == 0) ? ~pend_i : pend_i;
      m = ($urandom_range(0, 39) == 0) ? 2'($urandom_range(0, 3)) : mode_i;
      l = ($urandom_range(0, 7) == 0) ? PLEN_W'($urandom) : plen_i;
      step(p, m, l);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule